// File: doc/BRIEF.md
# Sixty-Four-Bit Free-Running Event Timer

This block holds a free-running 64-bit count behind a 32-bit register bus with plain read and write strobes. A four-bit prescale field slows the count relative to the input clock. A 64-bit match value is compared against the count every cycle. When matching is switched on and the count has reached or passed the match value, a sticky event flag is set. Software clears that flag by writing a one to it. An interrupt line follows the flag when both the interrupt and match enables are set.

For periodic events, a reload mode adds a 32-bit step to the match value each time an event fires, so the next event lands one period later without software help. Both halves of the count and both halves of the match value are writable. The carry from the low half into the high half happens inside a single clock, so software can read the count as high, then low, then high, and trust the result.

Top module: `wide_event_timer`

## Requirements
- R1: After reset every register reads zero, the count is stopped, and `irq` is low.
- R2: Registers are selected by byte address: count low 0x00, count high 0x04, control 0x08, status 0x0C, match low 0x10, match high 0x14, reload step 0x18. Any other offset reads zero. `rdata` carries the selected value in the cycle after `rd_en`. Control keeps only bits [3:0] and [11:8]; every other control bit reads zero.
- R3: Control bit 0 runs the count. While it is set, the count advances by one once every (prescale+1) clocks, where prescale is control bits [11:8]. While it is clear, the count holds its value.
- R4: The count is 64 bits wide, and the carry from the low half into the high half takes effect in the same clock the low half wraps. Writing a count half replaces that half.
- R5: With control bit 1 set, status bit 0 is set whenever count ≥ match, and this includes equality. Writing 1 to status bit 0 clears the flag. Writing 0 to it has no effect. If the condition still holds, the flag sets again and wins over the clear.
- R6: While control bit 1 is clear, the flag is never set, and writing either match half does not set it.
- R7: With control bits 1 and 3 both set, every cycle in which count ≥ match adds the zero-extended 32-bit reload step to the 64-bit match value. Without bit 3 the match value is left unchanged.
- R8: `irq` is high in the cycle after the flag, control bit 2 and control bit 1 are all set, and is low otherwise.
- R9: Any write to control restarts the prescale phase from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt, registered |

## Verification
Several properties are checked on every cycle by assertions:
- the prescale phase never passes the prescale field;
- a count with no tick and no write keeps its value;
- a wrap of the low half raises the high half in the same step;
- the flag only rises while matching is enabled and only falls on a clear;
- the match value moves only by one reload step or by a write;
- the interrupt never rises without the flag.

Some behaviour can only be shown by the bench's scenarios:
- the exact tick count for a given prescale and run span;
- the phase restart on a control write;
- the equality case and set-over-clear precedence;
- the final match value after several reloads, including a reload that carries into the high half;
- the register readback itself.

// File: rtl/wtmr_pkg.sv
package wtmr_pkg;
  localparam int unsigned PRESC_W = 4;

  typedef enum logic [2:0] {
    SEL_CNT_LO = 3'd0,
    SEL_CNT_HI = 3'd1,
    SEL_CTRL   = 3'd2,
    SEL_STAT   = 3'd3,
    SEL_CMP_LO = 3'd4,
    SEL_CMP_HI = 3'd5,
    SEL_STEP   = 3'd6,
    SEL_SPARE  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               reload;
    logic               irq_en;
    logic               cmp_en;
    logic               run;
  } ctrl_t;
endpackage

// File: rtl/wtmr_prescale.sv
module wtmr_prescale #(
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [PW-1:0] presc,
  input  logic          restart,
  output logic          tick
);
  logic [PW-1:0] phase;

  assign tick = run && (phase == presc);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (restart || !run || tick) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
    phase <= presc); // R3
endmodule

// File: rtl/wtmr_count.sv
module wtmr_count #(
  parameter int unsigned HW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [HW-1:0]   wdata,
  output logic [2*HW-1:0] cnt
);
  localparam int unsigned CW = 2 * HW;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt[HW-1:0]  <= wdata;
      if (wr_hi) cnt[CW-1:HW] <= wdata;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_lo && !wr_hi) |=> cnt == $past(cnt)); // R3
  AST_CNT_CARRY: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_lo && !wr_hi && (&cnt[HW-1:0]))
      |=> (cnt[HW-1:0] == '0) && (cnt[CW-1:HW] == $past(cnt[CW-1:HW]) + 1'b1)); // R4
endmodule

// File: rtl/wtmr_match.sv
module wtmr_match #(
  parameter int unsigned HW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*HW-1:0] cnt,
  input  logic            cmp_en,
  input  logic            reload,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic            wr_step,
  input  logic            clr,
  input  logic [HW-1:0]   wdata,
  output logic [2*HW-1:0] cmp,
  output logic [HW-1:0]   step,
  output logic            flag
);
  localparam int unsigned CW = 2 * HW;

  logic          hit;
  logic [CW-1:0] next_cmp;

  assign hit      = cmp_en && (cnt >= cmp);
  assign next_cmp = cmp + {{HW{1'b0}}, step};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cmp[HW-1:0]  <= wdata;
      if (wr_hi) cmp[CW-1:HW] <= wdata;
    end else if (hit && reload) begin
      cmp <= next_cmp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
    end else if (wr_step) begin
      step <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else begin
      flag <= hit || (flag && !clr);
    end
  end

  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(cmp_en)); // R6
  AST_FLAG_FALL_ON_CLR: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(clr)); // R5
  AST_RELOAD_STEP: assert property (@(posedge clk) disable iff (rst)
    (hit && reload && !wr_lo && !wr_hi)
      |=> cmp == $past(cmp) + {{HW{1'b0}}, $past(step)}); // R7
  AST_CMP_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!(hit && reload) && !wr_lo && !wr_hi) |=> $stable(cmp)); // R7
endmodule

// File: rtl/wide_event_timer.sv
module wide_event_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  import wtmr_pkg::*;

  localparam int unsigned CW        = 2 * DATA_W;
  localparam int unsigned PS_LSB    = 8;
  localparam int unsigned PS_MSB    = PS_LSB + PRESC_W - 1;
  localparam int unsigned SEL_LSB   = 2;

  reg_sel_e      sel;
  ctrl_t         ctrl;
  logic          wr_cnt_lo, wr_cnt_hi, wr_ctrl, wr_stat;
  logic          wr_cmp_lo, wr_cmp_hi, wr_step;
  logic          tick, flag;
  logic [CW-1:0] cnt, cmp;
  logic [DATA_W-1:0] step;
  logic [DATA_W-1:0] rd_mux;

  assign sel       = reg_sel_e'(addr[SEL_LSB +: 3]);
  assign wr_cnt_lo = wr_en && (sel == SEL_CNT_LO);
  assign wr_cnt_hi = wr_en && (sel == SEL_CNT_HI);
  assign wr_ctrl   = wr_en && (sel == SEL_CTRL);
  assign wr_stat   = wr_en && (sel == SEL_STAT);
  assign wr_cmp_lo = wr_en && (sel == SEL_CMP_LO);
  assign wr_cmp_hi = wr_en && (sel == SEL_CMP_HI);
  assign wr_step   = wr_en && (sel == SEL_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl <= '{presc:  wdata[PS_MSB:PS_LSB],
                reload: wdata[3],
                irq_en: wdata[2],
                cmp_en: wdata[1],
                run:    wdata[0]};
    end
  end

  wtmr_prescale #(.PW(PRESC_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl.run),
    .presc   (ctrl.presc),
    .restart (wr_ctrl),
    .tick    (tick)
  );

  wtmr_count #(.HW(DATA_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .wr_lo (wr_cnt_lo),
    .wr_hi (wr_cnt_hi),
    .wdata (wdata),
    .cnt   (cnt)
  );

  wtmr_match #(.HW(DATA_W)) u_match (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt),
    .cmp_en  (ctrl.cmp_en),
    .reload  (ctrl.reload),
    .wr_lo   (wr_cmp_lo),
    .wr_hi   (wr_cmp_hi),
    .wr_step (wr_step),
    .clr     (wr_stat && wdata[0]),
    .wdata   (wdata),
    .cmp     (cmp),
    .step    (step),
    .flag    (flag)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CNT_LO: rd_mux = cnt[DATA_W-1:0];
      SEL_CNT_HI: rd_mux = cnt[CW-1:DATA_W];
      SEL_CTRL: begin
        rd_mux[PS_MSB:PS_LSB] = ctrl.presc;
        rd_mux[3:0]           = {ctrl.reload, ctrl.irq_en, ctrl.cmp_en, ctrl.run};
      end
      SEL_STAT:   rd_mux[0] = flag;
      SEL_CMP_LO: rd_mux = cmp[DATA_W-1:0];
      SEL_CMP_HI: rd_mux = cmp[CW-1:DATA_W];
      SEL_STEP:   rd_mux = step;
      SEL_SPARE:  rd_mux = '0;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq <= flag && ctrl.irq_en && ctrl.cmp_en;
    end
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag)); // R8
endmodule

// File: tb/wide_event_timer_test.sv
module wide_event_timer_test;
  localparam time CLK_PERIOD = 10;
  localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08, A_STS = 5'h0C,
                         A_MLO = 5'h10, A_MHI = 5'h14, A_STP = 5'h18, A_SPR = 5'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        rvld = 1'b0;
  bit          done = 1'b0;

  int          vectors = 0;
  int          miscompares = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_event_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always @(posedge clk) rvld <= rd_en;

  always @(negedge clk) begin
    if (rvld && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (rdata !== e) begin
        miscompares++;
        $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // edge distance between consecutive writes is g (g >= 2)
  task automatic gap(input int g);
    repeat (g - 2) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    vectors++;
    if (irq !== e) begin
      miscompares++;
      $display("FAIL %s: irq=%b expected %b", t, irq, e);
    end
  endtask

  task automatic set_cnt(input logic [31:0] hi, input logic [31:0] lo);
    wr(A_CLO, lo);
    wr(A_CHI, hi);
  endtask

  task automatic run_span(input int p, input int g);
    wr(A_CTL, 32'h1 | (p << 8));
    gap(g);
    wr(A_CTL, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(A_CLO, 0, "R1 count low");
    rd(A_CHI, 0, "R1 count high");
    rd(A_CTL, 0, "R1 control");
    rd(A_STS, 0, "R1 status");
    rd(A_MLO, 0, "R1 match low");
    rd(A_MHI, 0, "R1 match high");
    rd(A_STP, 0, "R1 step");

    // R2: map, spare offset, control field masking
    rd(A_SPR, 0, "R2 spare offset");
    wr(A_CTL, 32'hFFFF_F0F0);
    rd(A_CTL, 32'h0, "R2 unused control bits");
    wr(A_CTL, 32'h0000_0F08);
    rd(A_CTL, 32'h0000_0F08, "R2 control readback");
    wr(A_CTL, 32'h0);
    wr(A_STP, 32'h1234_5678);
    rd(A_STP, 32'h1234_5678, "R2 step readback");

    // R3: prescale rates, R4: halves writable
    set_cnt(32'h2, 32'h10);
    rd(A_CHI, 32'h2, "R4 high half write");
    run_span(0, 10);
    rd(A_CLO, 32'h1A, "R3 prescale 0 span 10");
    rd(A_CHI, 32'h2, "R3 high unchanged");
    set_cnt(0, 0);
    run_span(3, 13);
    rd(A_CLO, 32'd3, "R3 prescale 3 span 13");
    set_cnt(0, 0);
    run_span(15, 40);
    rd(A_CLO, 32'd2, "R3 prescale 15 span 40");
    set_cnt(0, 0);
    run_span(3, 6);
    rd(A_CLO, 32'd1, "R3 prescale 3 span 6");
    repeat (5) @(negedge clk);
    rd(A_CLO, 32'd1, "R3 stopped count holds");

    // R9: control rewrite restarts prescale phase
    set_cnt(0, 0);
    wr(A_CTL, 32'h301);
    gap(3);
    wr(A_CTL, 32'h301);
    gap(3);
    wr(A_CTL, 32'h0);
    rd(A_CLO, 32'd0, "R9 phase restart");

    // R4: carry in one step
    set_cnt(32'h5, 32'hFFFF_FFFE);
    run_span(0, 3);
    rd(A_CLO, 32'h1, "R4 low after wrap");
    rd(A_CHI, 32'h6, "R4 high after carry");

    // R6, R5, R8: flag behaviour
    set_cnt(0, 100);
    wr(A_MLO, 50);
    wr(A_MHI, 0);
    rd(A_STS, 0, "R6 match write while disabled");
    wr(A_CTL, 32'h2);
    rd(A_STS, 1, "R5 count above match");
    chk_irq(1'b0, "R8 irq without irq enable");
    wr(A_CTL, 32'h6);
    @(negedge clk);
    chk_irq(1'b1, "R8 irq with both enables");
    wr(A_STS, 0);
    rd(A_STS, 1, "R5 write zero ignored");
    wr(A_STS, 1);
    rd(A_STS, 1, "R5 set wins over clear");
    wr(A_MHI, 1);
    wr(A_STS, 1);
    rd(A_STS, 0, "R5 clear when below match");
    @(negedge clk);
    chk_irq(1'b0, "R8 irq drops with flag");
    wr(A_MLO, 100);
    wr(A_STS, 1);
    rd(A_STS, 0, "R5 still below match");
    wr(A_MHI, 0);
    rd(A_STS, 1, "R5 equality sets flag");
    wr(A_CTL, 32'h4);
    @(negedge clk);
    chk_irq(1'b0, "R8 irq gated by match enable");
    rd(A_STS, 1, "R6 flag kept while disabled");
    wr(A_STS, 1);
    wr(A_MLO, 5);
    rd(A_STS, 0, "R6 no set while disabled");

    // R7: periodic reload
    set_cnt(0, 0);
    wr(A_MLO, 10);
    wr(A_MHI, 0);
    wr(A_STP, 7);
    wr(A_CTL, 32'hB);
    gap(30);
    wr(A_CTL, 32'h0);
    rd(A_CLO, 32'd30, "R3 count after reload run");
    rd(A_MLO, 32'd31, "R7 match after reloads");
    rd(A_MHI, 32'd0, "R7 match high");
    wr(A_STS, 1);
    set_cnt(1, 0);
    wr(A_MLO, 32'hFFFF_FFFC);
    wr(A_STP, 32'h1000_0000);
    wr(A_CTL, 32'hA);
    repeat (4) @(negedge clk);
    rd(A_MLO, 32'h0FFF_FFFC, "R7 64-bit reload low");
    rd(A_MHI, 32'h1, "R7 64-bit reload carry");
    wr(A_CTL, 32'h2);
    set_cnt(2, 0);
    repeat (3) @(negedge clk);
    rd(A_MHI, 32'h1, "R7 no reload when disabled");
    rd(A_MLO, 32'h0FFF_FFFC, "R7 low kept");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule